// File: doc/BRIEF.md
# Phase-Frequency Detector with Antibacklash Overlap

This block compares two pulse trains in a frequency synthesizer loop: a reference pulse train, taken from the divided-down reference oscillator, and a feedback pulse train, taken from the dual-modulus feedback divider (N = B·P + A). A rising edge on the reference sets the `up_o` output. A rising edge on the feedback sets the `dn_o` output. Once both are set, a reset is issued, and both outputs fall at the same clock edge. The difference in width between the two pulses follows both the phase error and the frequency error between the inputs, and it drives a charge pump that lies outside this block.

The reset that clears both outputs is held back by a delay counted in sampling-clock cycles. A two-bit code selects the delay. As a result, every comparison makes `up_o` and `dn_o` overlap for at least one cycle, even when the two edges coincide exactly. This antibacklash overlap keeps the detector's transfer curve free of a dead zone around zero phase error.

An edge that arrives during the overlap window is not lost. It is held and applied one cycle after the outputs clear. Both inputs are sampled levels that are synchronous to `clk`. No input has a flow-controlled interface: every pin is a plain control or status level.

Top module: `pfd_abl_top`

## Requirements
- R1: While `rst_n` is low, `up_o` and `dn_o` are 0 and input edges have no effect. After release, with both inputs low, both outputs stay 0.
- R2: A rising edge on `ref_i` is a 0 at one clock edge followed by a 1 at the next. It sets `up_o` high at the clock edge where the 1 is first sampled.
- R3: A rising edge on `fb_i` sets `dn_o` high at the clock edge where the 1 is first sampled.
- R4: Once `up_o` and `dn_o` are both high, they stay high together for exactly D cycles. They then fall at the same clock edge, and neither falls at any other time.
- R5: D is set by `abw_sel_i` as D = code + 1: 2'b00 gives 1 cycle, 2'b01 gives 2, 2'b10 gives 3 and 2'b11 gives 4.
- R6: When the feedback edge lags the reference edge by s cycles, `up_o` is high for s + D cycles and `dn_o` is high for D cycles.
- R7: When the feedback edge leads the reference edge by s cycles, `dn_o` is high for s + D cycles and `up_o` is high for D cycles.
- R8: While one output is high and the other is low, further rising edges on the high side's input are ignored. That output stays high in one unbroken pulse until the overlap clear.
- R9: A rising edge that arrives on either input while both outputs are high is held. At the clear, that output goes low for exactly one cycle and is then set again.
- R10: Edges that arrive in the same cycle give two pulses of equal width D, and D is never zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_i | input | 1 | Divided reference pulse level |
| fb_i | input | 1 | Divided feedback pulse level |
| abw_sel_i | input | 2 | Antibacklash overlap width code (D = code + 1 cycles) |
| up_o | output | 1 | Reference-leads output pulse |
| dn_o | output | 1 | Feedback-leads output pulse |

## Verification
The bench walks a table of edge pairs:
- coincident edges under all four width codes, which separates the delay mapping from the phase response;
- feedback lagging by 3 and 5 cycles, and leading by 1 and 4 cycles, which shows that the extra width lands on the correct output only;
- a one-cycle lag under the widest code, which tests the interaction between a small phase error and a long overlap.

Directed runs then add repeated reference edges before any feedback edge, which is the frequency-error case where the extra edges must be ignored. A further run sends a second edge inside the overlap window, which must come out as a one-cycle gap followed by a new pulse rather than being dropped.

// File: rtl/pfd_abl_pkg.sv
package pfd_abl_pkg;

  // Index of the two compared channels.
  typedef enum logic {
    CH_REF = 1'b0,
    CH_FB  = 1'b1
  } pfd_ch_e;

  localparam int unsigned NUM_CH = 2;

  // Overlap length in cycles for a given width code.
  function automatic int unsigned overlap_cycles(input int unsigned code);
    return code + 1;
  endfunction

endpackage

// File: rtl/pfd_rise_det.sv
module pfd_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_i;
  end

  assign rise_o = rst_n & lvl_i & ~lvl_q;

endmodule

// File: rtl/pfd_side_ff.sv
module pfd_side_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_i,   // rising edge seen this cycle
  input  logic hold_i,   // both outputs high: overlap window
  input  logic clear_i,  // end of overlap window
  output logic q_o
);

  logic q_q;
  logic pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_q    <= 1'b0;
      pend_q <= 1'b0;
    end else if (clear_i) begin
      q_q    <= 1'b0;
      pend_q <= pend_q | rise_i;
    end else if (hold_i) begin
      pend_q <= pend_q | rise_i;
    end else begin
      q_q    <= q_q | rise_i | pend_q;
      pend_q <= 1'b0;
    end
  end

  assign q_o = q_q;

  AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_i && !hold_i && !clear_i) |=> q_o);  // R2

  AST_PENDING_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !hold_i && !clear_i) |=> q_o);  // R9

  AST_STAYS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (q_o && !clear_i) |=> q_o);  // R8

endmodule

// File: rtl/pfd_abl_timer.sv
module pfd_abl_timer #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             both_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             clear_o
);

  logic [SEL_W-1:0] cnt_q;

  // The window lasts sel_i + 1 cycles; it clears once the count reaches sel_i.
  assign clear_o = both_i && (cnt_q >= sel_i);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!both_i || clear_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + SEL_W'(1);
  end

  AST_CNT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !both_i |=> (cnt_q == '0) || both_i);  // R4

endmodule

// File: rtl/pfd_abl_top.sv
module pfd_abl_top #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_i,
  input  logic             fb_i,
  input  logic [SEL_W-1:0] abw_sel_i,
  output logic             up_o,
  output logic             dn_o
);
  import pfd_abl_pkg::*;

  localparam int unsigned MAX_DLY = overlap_cycles((1 << SEL_W) - 1);

  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] rise;
  logic [NUM_CH-1:0] q;
  logic              both;
  logic              clear;

  assign lvl[CH_REF] = ref_i;
  assign lvl[CH_FB]  = fb_i;
  assign both        = &q;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pfd_rise_det u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_i (lvl[g]),
      .rise_o(rise[g])
    );
    pfd_side_ff u_side (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (rise[g]),
      .hold_i (both),
      .clear_i(clear),
      .q_o    (q[g])
    );
  end

  pfd_abl_timer #(.SEL_W(SEL_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .both_i (both),
    .sel_i  (abw_sel_i),
    .clear_o(clear)
  );

  assign up_o = q[CH_REF];
  assign dn_o = q[CH_FB];

  // Checker state: length of the current run of overlap cycles.
  logic [SEL_W:0] ovl_run_q;
  always_ff @(posedge clk) begin
    if (!rst_n)            ovl_run_q <= '0;
    else if (up_o && dn_o) ovl_run_q <= ovl_run_q + (SEL_W+1)'(1);
    else                   ovl_run_q <= '0;
  end

  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (up_o && dn_o) |-> (ovl_run_q < (SEL_W+1)'(MAX_DLY)));  // R4

  AST_FALL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(up_o) |-> $fell(dn_o));  // R4

  AST_FALL_TOGETHER_DN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dn_o) |-> $fell(up_o));  // R4

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!up_o && !dn_o));  // R1

endmodule

// File: tb/pfd_abl_top_tb_top.sv
module pfd_abl_top_tb_top;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WIN        = 24;
  localparam int  NV         = 9;
  // Fields: code, ref cycle, fb cycle, expected up width, expected dn width
  localparam int VEC [NV][5] = '{
    '{0, 2, 2, 1, 1},
    '{1, 2, 2, 2, 2},
    '{2, 2, 2, 3, 3},
    '{3, 2, 2, 4, 4},
    '{0, 2, 5, 4, 1},
    '{2, 2, 7, 8, 3},
    '{1, 6, 2, 2, 6},
    '{3, 3, 4, 5, 4},
    '{0, 4, 3, 1, 2}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_i = 1'b0;
  logic       fb_i = 1'b0;
  logic [1:0] abw_sel_i = 2'b00;
  logic       up_o;
  logic       dn_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_abl_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_i    (ref_i),
    .fb_i     (fb_i),
    .abw_sel_i(abw_sel_i),
    .up_o     (up_o),
    .dn_o     (dn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drives ref/fb pulses in the listed cycles and counts high cycles and rises.
  task automatic run_win(input int r0, input int r1, input int f0, input int f1,
                         output int uc, output int dc, output int ur, output int dr,
                         output logic [WIN-1:0] utr);
    logic pu, pd;
    uc = 0; dc = 0; ur = 0; dr = 0; utr = '0;
    pu = 1'b0; pd = 1'b0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      utr[i] = up_o;
      if (up_o) uc++;
      if (dn_o) dc++;
      if (up_o && !pu) ur++;
      if (dn_o && !pd) dr++;
      pu = up_o; pd = dn_o;
      ref_i = (i == r0) || (i == r1);
      fb_i  = (i == f0) || (i == f1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int uc, dc, ur, dr;
    logic [WIN-1:0] utr;

    // R1: reset holds outputs low even with edges present
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      ref_i = i[0];
      fb_i  = ~i[0];
      if (i > 0) chk(!up_o && !dn_o, "R1 reset outputs", {up_o, dn_o}, 0);
    end
    @(negedge clk);
    ref_i = 1'b0; fb_i = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(!up_o && !dn_o, "R1 idle after release", {up_o, dn_o}, 0);

    // R2 R3 R4 R5 R6 R7 R10: vector table
    for (int v = 0; v < NV; v++) begin
      abw_sel_i = 2'(VEC[v][0]);
      run_win(VEC[v][1], -1, VEC[v][2], -1, uc, dc, ur, dr, utr);
      chk(uc == VEC[v][3], "R2/R5/R6/R7 up width", uc, VEC[v][3]);
      chk(dc == VEC[v][4], "R3/R5/R6/R7 dn width", dc, VEC[v][4]);
      chk(ur == 1 && dr == 1, "R4 one pulse each", ur * 10 + dr, 11);
      chk(!up_o && !dn_o, "R4 both cleared", {up_o, dn_o}, 0);
      if (VEC[v][1] == VEC[v][2])
        chk(uc == dc && uc >= 1, "R10 equal nonzero widths", uc - dc, 0);
      // R2: up must be high right after the edge that samples the ref rise
      chk(utr[VEC[v][1] + 1] == 1'b1, "R2 set latency", utr[VEC[v][1] + 1], 1);
    end

    // R8: repeated ref edges before fb; code 01 gives D=2, width (10-1)+2
    abw_sel_i = 2'b01;
    run_win(1, 4, 10, -1, uc, dc, ur, dr, utr);
    chk(ur == 1, "R8 single up pulse", ur, 1);
    chk(uc == 11, "R8 up width", uc, 11);
    chk(dc == 2, "R8 dn width", dc, 2);

    // R9: second ref edge inside a 4-cycle overlap window
    abw_sel_i = 2'b11;
    run_win(2, 4, 2, 12, uc, dc, ur, dr, utr);
    chk(utr[7] == 1'b0, "R9 gap after clear", utr[7], 0);
    chk(utr[8] == 1'b1, "R9 held edge applied", utr[8], 1);
    chk(ur == 2, "R9 up pulses", ur, 2);
    chk(uc == 13, "R9 up total width", uc, 13);
    chk(dc == 8, "R9 dn total width", dc, 8);
    chk(!up_o && !dn_o, "R9 final idle", {up_o, dn_o}, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule